// File: doc/BRIEF.md
# SEC-DED Protected Word Memory

This block is a synchronous single-port word store whose every 32-bit word is kept together with seven check bits of an extended Hamming code. A host write encodes the word and stores data and check bits together. A host read returns the word one cycle later, with any single flipped data bit repaired, and raises an error flag when the stored word holds two flipped bits that cannot be repaired. Host reads never modify the stored word, so a word with a latent single-bit fault is repaired again on every read.

A separate scrub port steals the memory from the host. A scrub request reads one address, checks it and, when the word holds a correctable fault, writes the corrected code word back in place. A word with an uncorrectable fault is left as it is. A scrub request always wins over a host access in the same cycle, and the host is held off with a stall output until the scrub has finished.

A bypass input turns the coding off. While bypass is high, reads return the raw stored data bits with both error flags low, writes replace only the data bits and keep the stored check bits, and scrubs write nothing. This makes it possible to plant faults through the normal ports and to observe the raw contents of a word after a scrub.

Top module: `ecc_word_store`

## Requirements
- R1: A host write with bypass low, followed by a host read with bypass low, returns the written word with rd_corrected and rd_mbe low; rd_valid is high in exactly the cycle after the cycle in which the read was accepted.
- R2: When the stored data differs from the last encoded word in exactly one data bit, a host read with bypass low returns the encoded word, with rd_corrected high and rd_mbe low.
- R3: When the stored data differs from the last encoded word in exactly two data bits, a host read with bypass low raises rd_mbe, keeps rd_corrected low and returns the stored data bits unchanged.
- R4: A host write with bypass high replaces only the 32 data bits of the word; the stored check bits keep the value of the last write made with bypass low.
- R5: A host read with bypass high returns the raw stored data bits with rd_corrected and rd_mbe low.
- R6: A scrub of a word holding a single data-bit fault raises scrub_fixed in its check cycle and writes the corrected word back, so that a later raw read returns the encoded word.
- R7: A scrub of a word holding a two-bit fault raises scrub_mbe in its check cycle and leaves the stored word unchanged.
- R8: A scrub started while bypass is high keeps scrub_fixed and scrub_mbe low and writes nothing to the store.
- R9: When scrub_req and host_req are high in the same cycle, the scrub is served first; host_stall is high in the request cycle and in the scrub's check cycle, no host read data is returned in the check cycle, and the host access completes after the scrub.
- R10: A scrub accepted at one clock edge makes scrub_done high for exactly the following cycle, and a clean word gives scrub_fixed and scrub_mbe low.
- R11: During and right after reset, with no request applied, rd_valid, scrub_done and host_stall are low.
- R12: Host reads never write to the store: a word with a single data-bit fault is corrected on every read, and a raw read afterwards still shows the fault.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bypass | input | 1 | Coding off when high |
| host_req | input | 1 | Host access request |
| host_we | input | 1 | Host access is a write when high |
| host_addr | input | ADDR_W | Host word address |
| host_wdata | input | 32 | Host write data |
| host_stall | output | 1 | Host request not accepted this cycle |
| rd_valid | output | 1 | Host read data valid |
| rd_data | output | 32 | Host read data, corrected where possible |
| rd_corrected | output | 1 | Read data had a correctable fault |
| rd_mbe | output | 1 | Read data holds an uncorrectable fault |
| scrub_req | input | 1 | Scrub request |
| scrub_addr | input | ADDR_W | Address to scrub |
| scrub_done | output | 1 | Scrub check cycle |
| scrub_fixed | output | 1 | Scrubbed word was corrected and written back |
| scrub_mbe | output | 1 | Scrubbed word has an uncorrectable fault |

## Verification
On every cycle the assertions check that read data comes only one cycle after an accepted read, that a returned word differs from the raw stored data in at most one bit, that the error flag never accompanies a correction, that a scrub check lasts one cycle, never overlaps returned host data, and writes nothing under bypass. Whether a correction is the right one, whether a write-back really repaired the store, and whether the stored check bits survive a raw write can only be shown by the bench's scenarios, which plant faults through raw writes and then compare coded and raw reads against a model of golden and raw contents.

// File: rtl/ecc_word_pkg.sv
package ecc_word_pkg;

  parameter int DATA_W = 32;

  // smallest number of Hamming parity bits covering DATA_W data bits
  function automatic int ham_bits(int dw);
    int r;
    r = 1;
    while ((1 << r) < dw + r + 1) r++;
    return r;
  endfunction

  localparam int HAM_W   = ham_bits(DATA_W);
  localparam int CHK_W   = HAM_W + 1;
  localparam int MAX_POS = DATA_W + HAM_W;

  typedef enum logic {SCR_IDLE, SCR_CHECK} scrub_st_e;

  // code position (1-based) of data bit idx: positions that are not powers of two
  function automatic int data_pos(int idx);
    int p;
    int n;
    p = 0;
    n = -1;
    while (n < idx) begin
      p++;
      if ((p & (p - 1)) != 0) n++;
    end
    return p;
  endfunction

  // check bits: [HAM_W-1:0] Hamming parities, [HAM_W] overall parity
  function automatic logic [CHK_W-1:0] check_of(logic [DATA_W-1:0] d);
    logic [CHK_W-1:0] c;
    int p;
    c = '0;
    for (int i = 0; i < DATA_W; i++) begin
      p = data_pos(i);
      for (int r = 0; r < HAM_W; r++) begin
        if (p[r]) c[r] = c[r] ^ d[i];
      end
    end
    c[HAM_W] = (^d) ^ (^c[HAM_W-1:0]);
    return c;
  endfunction

  function automatic logic [HAM_W-1:0] syndrome_of(logic [DATA_W-1:0] d,
                                                   logic [CHK_W-1:0]  chk);
    logic [CHK_W-1:0] fresh;
    fresh = check_of(d);
    return fresh[HAM_W-1:0] ^ chk[HAM_W-1:0];
  endfunction

  // parity of the whole received code word; even on a fault-free word
  function automatic logic odd_of(logic [DATA_W-1:0] d, logic [CHK_W-1:0] chk);
    return (^d) ^ (^chk);
  endfunction

endpackage

// File: rtl/ecc_mem_array.sv
module ecc_mem_array
  import ecc_word_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rd_en,
  input  logic              d_we,
  input  logic              c_we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [CHK_W-1:0]  wchk,
  output logic [DATA_W-1:0] rdata,
  output logic [CHK_W-1:0]  rchk
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] data_mem [DEPTH];
  logic [CHK_W-1:0]  chk_mem  [DEPTH];

  // data and check bits carry separate write enables
  always_ff @(posedge clk) begin
    if (d_we) data_mem[addr] <= wdata;
    if (c_we) chk_mem[addr]  <= wchk;
    if (rd_en) begin
      rdata <= data_mem[addr];
      rchk  <= chk_mem[addr];
    end
  end

endmodule

// File: rtl/ecc_encoder.sv
module ecc_encoder
  import ecc_word_pkg::*;
(
  input  logic [DATA_W-1:0] data,
  output logic [CHK_W-1:0]  chk
);

  always_comb chk = check_of(data);

endmodule

// File: rtl/ecc_decoder.sv
module ecc_decoder
  import ecc_word_pkg::*;
(
  input  logic [DATA_W-1:0] data,
  input  logic [CHK_W-1:0]  chk,
  input  logic              bypass,
  output logic [DATA_W-1:0] data_out,
  output logic              fixed,
  output logic              mbe
);

  logic [HAM_W-1:0]  syn;
  logic              odd;
  logic              pos_ok;
  logic [DATA_W-1:0] flip;

  always_comb begin
    syn    = syndrome_of(data, chk);
    odd    = odd_of(data, chk);
    pos_ok = (syn <= HAM_W'(MAX_POS));
    fixed  = ~bypass & odd & pos_ok;
    mbe    = ~bypass & ((~odd & (syn != '0)) | (odd & ~pos_ok));
  end

  // one comparator per data bit against its code position
  for (genvar i = 0; i < DATA_W; i++) begin : g_flip
    localparam logic [HAM_W-1:0] POS = HAM_W'(data_pos(i));
    assign flip[i] = fixed & (syn == POS);
  end

  assign data_out = data ^ flip;

endmodule

// File: rtl/ecc_scrub_ctrl.sv
module ecc_scrub_ctrl
  import ecc_word_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic [ADDR_W-1:0] addr,
  input  logic              dec_fixed,
  input  logic              dec_mbe,
  output logic              start,
  output logic              busy,
  output logic              wr,
  output logic [ADDR_W-1:0] addr_q,
  output logic              done,
  output logic              fixed_o,
  output logic              mbe_o
);

  scrub_st_e state_q;

  assign start   = req & (state_q == SCR_IDLE);
  assign busy    = (state_q == SCR_CHECK);
  assign wr      = busy & dec_fixed;
  assign done    = busy;
  assign fixed_o = busy & dec_fixed;
  assign mbe_o   = busy & dec_mbe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SCR_IDLE;
      addr_q  <= '0;
    end else begin
      case (state_q)
        SCR_IDLE: if (start) begin
          state_q <= SCR_CHECK;
          addr_q  <= addr;
        end
        default: state_q <= SCR_IDLE;
      endcase
    end
  end

  // R10
  scrub_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !busy);

  // R10
  scrub_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);

endmodule

// File: rtl/ecc_word_store.sv
module ecc_word_store
  import ecc_word_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bypass,
  input  logic              host_req,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic              host_stall,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_corrected,
  output logic              rd_mbe,
  input  logic              scrub_req,
  input  logic [ADDR_W-1:0] scrub_addr,
  output logic              scrub_done,
  output logic              scrub_fixed,
  output logic              scrub_mbe
);

  logic              scrub_start;
  logic              scrub_busy;
  logic              scrub_wr;
  logic [ADDR_W-1:0] scrub_addr_q;
  logic              host_go;
  logic              host_rd_go;
  logic              host_wr_go;
  logic              arr_rd_en;
  logic              arr_d_we;
  logic              arr_c_we;
  logic [ADDR_W-1:0] arr_addr;
  logic [DATA_W-1:0] arr_wdata;
  logic [CHK_W-1:0]  arr_wchk;
  logic [DATA_W-1:0] arr_rdata;
  logic [CHK_W-1:0]  arr_rchk;
  logic [DATA_W-1:0] dec_data;
  logic              dec_fixed;
  logic              dec_mbe;
  logic              rd_pend_q;
  logic              byp_rd_q;

  // scrub owns the store in its request cycle and its check cycle
  assign host_stall = scrub_req | scrub_busy;
  assign host_go    = host_req & ~host_stall;
  assign host_rd_go = host_go & ~host_we;
  assign host_wr_go = host_go & host_we;

  assign arr_rd_en = scrub_start | host_rd_go;
  assign arr_d_we  = scrub_wr | host_wr_go;
  assign arr_c_we  = scrub_wr | (host_wr_go & ~bypass);
  assign arr_wdata = scrub_wr ? dec_data : host_wdata;

  always_comb begin
    if (scrub_wr)         arr_addr = scrub_addr_q;
    else if (scrub_start) arr_addr = scrub_addr;
    else                  arr_addr = host_addr;
  end

  ecc_encoder u_enc (
    .data (arr_wdata),
    .chk  (arr_wchk)
  );

  ecc_mem_array #(.ADDR_W(ADDR_W)) u_mem (
    .clk   (clk),
    .rd_en (arr_rd_en),
    .d_we  (arr_d_we),
    .c_we  (arr_c_we),
    .addr  (arr_addr),
    .wdata (arr_wdata),
    .wchk  (arr_wchk),
    .rdata (arr_rdata),
    .rchk  (arr_rchk)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_pend_q <= 1'b0;
      byp_rd_q  <= 1'b0;
    end else begin
      rd_pend_q <= host_rd_go;
      if (arr_rd_en) byp_rd_q <= bypass;
    end
  end

  // one decoder serves the host read path and the scrub check
  ecc_decoder u_dec (
    .data     (arr_rdata),
    .chk      (arr_rchk),
    .bypass   (byp_rd_q),
    .data_out (dec_data),
    .fixed    (dec_fixed),
    .mbe      (dec_mbe)
  );

  ecc_scrub_ctrl #(.ADDR_W(ADDR_W)) u_scrub (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (scrub_req),
    .addr      (scrub_addr),
    .dec_fixed (dec_fixed),
    .dec_mbe   (dec_mbe),
    .start     (scrub_start),
    .busy      (scrub_busy),
    .wr        (scrub_wr),
    .addr_q    (scrub_addr_q),
    .done      (scrub_done),
    .fixed_o   (scrub_fixed),
    .mbe_o     (scrub_mbe)
  );

  assign rd_valid     = rd_pend_q;
  assign rd_data      = dec_data;
  assign rd_corrected = rd_pend_q & dec_fixed;
  assign rd_mbe       = rd_pend_q & dec_mbe;

  // R1
  rd_valid_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(host_req && !host_we && !host_stall));

  // R2
  single_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> ($countones(rd_data ^ arr_rdata) <= 1));

  // R3
  mbe_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_mbe |-> (rd_valid && !rd_corrected));

  // R9
  scrub_no_host_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scrub_done |-> !rd_valid);

  // R8
  bypass_scrub_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scrub_busy && byp_rd_q) |-> (!arr_d_we && !arr_c_we));

endmodule

// File: tb/ecc_word_store_tb.sv
module ecc_word_store_tb;

  localparam int AW    = 4;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bypass = 1'b0;
  logic          host_req = 1'b0;
  logic          host_we = 1'b0;
  logic [AW-1:0] host_addr = '0;
  logic [31:0]   host_wdata = '0;
  logic          host_stall;
  logic          rd_valid;
  logic [31:0]   rd_data;
  logic          rd_corrected;
  logic          rd_mbe;
  logic          scrub_req = 1'b0;
  logic [AW-1:0] scrub_addr = '0;
  logic          scrub_done;
  logic          scrub_fixed;
  logic          scrub_mbe;

  always #10 clk = ~clk;

  ecc_word_store #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .bypass(bypass),
    .host_req(host_req), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_stall(host_stall),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_corrected(rd_corrected),
    .rd_mbe(rd_mbe), .scrub_req(scrub_req), .scrub_addr(scrub_addr),
    .scrub_done(scrub_done), .scrub_fixed(scrub_fixed), .scrub_mbe(scrub_mbe)
  );

  int checks = 0;
  int fails  = 0;

  // model: last encoded word and raw stored data bits per address
  bit [31:0] gold [DEPTH];
  bit [31:0] raw  [DEPTH];

  bit        mon_on  = 0;
  bit        exp_rv  = 0;
  bit [31:0] exp_d   = '0;
  bit        exp_fix = 0;
  bit        exp_mbe = 0;
  string     exp_tag = "R1";
  bit        exp_sd  = 0;
  bit        exp_sfix = 0;
  bit        exp_smbe = 0;
  string     s_tag   = "R10";

  task automatic check(bit ok, string tag, string what, longint act, longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
    end
  endtask

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  // per-cycle comparison against the model, mid high phase
  always @(posedge clk) begin
    #5;
    if (mon_on) begin
      check(rd_valid == exp_rv, exp_tag, "rd_valid", rd_valid, exp_rv);
      if (exp_rv) begin
        check(rd_data == exp_d, exp_tag, "rd_data", rd_data, exp_d);
        check(rd_corrected == exp_fix, exp_tag, "rd_corrected", rd_corrected, exp_fix);
        check(rd_mbe == exp_mbe, exp_tag, "rd_mbe", rd_mbe, exp_mbe);
      end
      check(scrub_done == exp_sd, s_tag, "scrub_done", scrub_done, exp_sd);
      if (exp_sd) begin
        check(scrub_fixed == exp_sfix, s_tag, "scrub_fixed", scrub_fixed, exp_sfix);
        check(scrub_mbe == exp_smbe, s_tag, "scrub_mbe", scrub_mbe, exp_smbe);
      end
    end
  end

  task automatic predict(int a, bit byp);
    int n;
    n = $countones(raw[a] ^ gold[a]);
    exp_fix = 0;
    exp_mbe = 0;
    exp_d   = raw[a];
    if (!byp) begin
      if (n == 1) begin
        exp_d   = gold[a];
        exp_fix = 1;
      end else if (n >= 2) begin
        exp_mbe = 1;
      end
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic wr(int a, bit [31:0] d, bit byp);
    host_req = 1; host_we = 1; host_addr = AW'(a); host_wdata = d; bypass = byp;
    @(posedge clk);
    @(negedge clk);
    host_req = 0; host_we = 0;
    raw[a] = d;
    if (!byp) gold[a] = d;
  endtask

  task automatic rd(int a, bit byp, string tag);
    host_req = 1; host_we = 0; host_addr = AW'(a); bypass = byp;
    @(posedge clk);
    #1;
    predict(a, byp);
    exp_tag = tag;
    exp_rv  = 1;
    @(negedge clk);
    exp_rv = 0;
    host_req = 0;
  endtask

  task automatic scrub(int a, bit byp, string tag);
    int n;
    scrub_req = 1; scrub_addr = AW'(a); bypass = byp;
    #1;
    check(host_stall == 1'b1, "R9", "host_stall on scrub request", host_stall, 1);
    @(posedge clk);
    #1;
    n = $countones(raw[a] ^ gold[a]);
    s_tag    = tag;
    exp_sfix = !byp && (n == 1);
    exp_smbe = !byp && (n >= 2);
    exp_sd   = 1;
    @(negedge clk);
    scrub_req = 0;
    exp_sd = 0;
    if (exp_sfix) raw[a] = gold[a];
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    report();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11: outputs quiet in reset
    check(rd_valid == 0 && scrub_done == 0 && host_stall == 0, "R11",
          "outputs in reset", {rd_valid, scrub_done, host_stall}, 0);
    rst_n = 1;
    @(negedge clk);
    check(rd_valid == 0 && scrub_done == 0 && host_stall == 0, "R11",
          "outputs after reset", {rd_valid, scrub_done, host_stall}, 0);
    mon_on = 1;

    // R1: encoded writes and reads of every word
    for (int a = 0; a < DEPTH; a++)
      wr(a, 32'hA5C3_0F96 ^ (32'(a) * 32'h0101_1111) ^ (32'(a) << 27), 0);
    for (int a = 0; a < DEPTH; a++) rd(a, 0, "R1");
    wr(2, 32'hFFFF_FFFF, 0);
    rd(2, 0, "R1");
    wr(4, 32'h0000_0000, 0);
    rd(4, 0, "R1");

    // R4/R5: raw write keeps check bits; raw read shows the planted fault
    wr(3, gold[3] ^ 32'h0000_0001, 1);
    rd(3, 1, "R5");
    rd(3, 0, "R4");
    // R12: corrected again, store untouched
    rd(3, 0, "R12");
    rd(3, 1, "R12");

    // R2: single faults at other positions
    wr(5, gold[5] ^ 32'h8000_0000, 1);
    rd(5, 0, "R2");
    wr(6, gold[6] ^ 32'h0002_0000, 1);
    rd(6, 0, "R2");
    wr(2, 32'hFFFF_FFFE, 1);
    rd(2, 0, "R2");

    // R3: double fault
    wr(7, gold[7] ^ 32'h0000_0204, 1);
    rd(7, 0, "R3");
    wr(4, 32'h8000_0001, 1);
    rd(4, 0, "R3");

    // R6: scrub repairs a single fault in place
    scrub(3, 0, "R6");
    rd(3, 1, "R6");
    rd(3, 0, "R6");

    // R7: scrub leaves a double fault alone
    scrub(7, 0, "R7");
    rd(7, 1, "R7");
    rd(7, 0, "R7");

    // R8: scrub under bypass writes nothing
    wr(8, gold[8] ^ 32'h0040_0000, 1);
    scrub(8, 1, "R8");
    rd(8, 1, "R8");
    rd(8, 0, "R8");

    // R10: scrub of a clean word
    scrub(0, 0, "R10");
    rd(0, 0, "R10");

    // R9: scrub and host read in the same cycle
    host_req = 1; host_we = 0; host_addr = AW'(5); bypass = 0;
    scrub_req = 1; scrub_addr = AW'(5);
    #1;
    check(host_stall == 1'b1, "R9", "host_stall request cycle", host_stall, 1);
    @(posedge clk);
    #1;
    s_tag = "R9"; exp_sfix = 1; exp_smbe = 0; exp_sd = 1;
    @(negedge clk);
    scrub_req = 0;
    exp_sd = 0;
    raw[5] = gold[5];
    #1;
    check(host_stall == 1'b1, "R9", "host_stall check cycle", host_stall, 1);
    @(posedge clk);
    @(negedge clk);
    #1;
    check(host_stall == 1'b0, "R9", "host_stall released", host_stall, 0);
    @(posedge clk);
    #1;
    predict(5, 0);
    exp_tag = "R9";
    exp_rv = 1;
    @(negedge clk);
    exp_rv = 0;
    host_req = 0;

    // R1: encoded rewrite clears a double fault
    wr(7, 32'h1357_9BDF, 0);
    rd(7, 0, "R1");
    rd(7, 1, "R1");

    repeat (2) @(negedge clk);
    report();
    $finish;
  end

endmodule